// File: doc/BRIEF.md
# Table-Lookup Constant Coefficient Multiplier

This block multiplies an unsigned 10-bit sample by a 13-bit constant coefficient without a gate-level multiplier. It keeps a 32-entry table in which entry k holds k times the coefficient. The sample is cut into 5-bit chunks. Each chunk reads its own copy of the table in the same clock. The partial product of the upper chunk is then shifted left by five places and added to the partial product of the lower chunk, which gives the 23-bit result.

The coefficient is loaded through a strobe. That strobe starts a sequential fill of the table copies, one entry per clock, using a running sum of the coefficient. While the fill runs, a busy flag is high and incoming samples are dropped. The data path is a plain pipeline with no back-pressure. A result appears two clocks after its sample was accepted.

Top module: `tlm_lut_mult`

## Requirements
- R1: While reset is held (synchronous, active low) and on the first clock after release, `product_o` is 0, `valid_o` is 0 and `busy_o` is 0.
- R2: Until the first coefficient load, every table entry is zero, so an accepted sample yields `product_o` = 0 with `valid_o` high.
- R3: A `coef_load_i` pulse sampled while `busy_o` is low raises `busy_o` at the next clock. `busy_o` then stays high for exactly 32 clocks, one for each table entry written.
- R4: For a sample s accepted after a completed load of coefficient C, `product_o` equals s*C as a 23-bit unsigned value. This holds for every s in 0..1023, including s = 1023 with C = 8191.
- R5: `valid_o` goes high exactly two clocks after a clock at which `valid_i` is high and `busy_o` is low. It is never high otherwise.
- R6: A sample presented with `valid_i` high at a clock where `busy_o` is high is dropped and produces no `valid_o` pulse.
- R7: A `coef_load_i` pulse at a clock where `busy_o` is high is ignored. The table keeps the coefficient of the fill in progress.
- R8: While `valid_o` is low, `product_o` keeps the value of the last result.
- R9: Samples accepted on consecutive clocks give results on consecutive clocks, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_load_i | input | 1 | Strobe that latches `coef_i` and starts the table fill |
| coef_i | input | 13 | Unsigned coefficient |
| busy_o | output | 1 | High while the table is being filled |
| valid_i | input | 1 | Sample qualifier |
| sample_i | input | 10 | Unsigned sample |
| valid_o | output | 1 | Result qualifier |
| product_o | output | 23 | Unsigned product |

## Verification
A sample driven before clock edge E is read from the tables at E and summed at E+1. Its result is therefore checked at the falling edge that follows E+1, two falling edges after it was driven. The bench keeps a two-deep shadow of what it drove and compares each output against the arithmetic product of the sample from two edges earlier. The busy window begins at the edge that samples the load strobe and is counted over the 32 falling edges after it. A sample or load driven during the last busy edge is still expected to be dropped, and the outputs are checked for two edges after busy falls.

// File: rtl/tlm_pkg.sv
// Package: shared types for the table-lookup multiplier.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tlm_pkg;

    // Table fill sequencer state.
    typedef enum logic [0:0] {
        GEN_IDLE = 1'b0,
        GEN_FILL = 1'b1
    } gen_state_t;

endpackage

// File: rtl/tlm_table_gen.sv
// Module: tlm_table_gen
// Fills the multiple table after a coefficient load. Entry k receives k*C.
// The value comes from a running sum, so no multiplier is needed. One entry
// is written per clock, and busy_o stays high for the whole fill.
// Assumes: ENTRY_W is wide enough for (2**ADDR_W - 1) * (2**COEF_W - 1).
//          Load strobes that arrive during a fill are dropped.
module tlm_table_gen
    import tlm_pkg::*;
#(
    parameter int COEF_W  = 13,
    parameter int ADDR_W  = 5,
    parameter int ENTRY_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [COEF_W-1:0]  coef_i,
    output logic               busy_o,
    output logic [COEF_W-1:0]  coef_o,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [ENTRY_W-1:0] wr_data_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'((1 << ADDR_W) - 1);

    gen_state_t         state_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [ENTRY_W-1:0] acc_q;
    logic [COEF_W-1:0]  coef_q;

    // Sequencer: latch coefficient, then step the index and running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
            idx_q   <= '0;
            acc_q   <= '0;
            coef_q  <= '0;
        end else begin
            case (state_q)
                GEN_IDLE: begin
                    if (load_i) begin
                        coef_q  <= coef_i;
                        idx_q   <= '0;
                        acc_q   <= '0;
                        state_q <= GEN_FILL;
                    end
                end
                GEN_FILL: begin
                    idx_q <= idx_q + 1'b1;
                    acc_q <= acc_q + ENTRY_W'(coef_q);
                    if (idx_q == LAST_IDX) begin
                        state_q <= GEN_IDLE;
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

    // Write port and status driven from the sequencer state.
    always_comb begin
        busy_o    = (state_q == GEN_FILL);
        wr_en_o   = (state_q == GEN_FILL);
        wr_addr_o = idx_q;
        wr_data_o = acc_q;
        coef_o    = coef_q;
    end

    // R3: an accepted load starts a fill at the next clock.
    assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> busy_o);

    // R3: the fill ends right after the last entry is written.
    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_addr_o == LAST_IDX) |=> !busy_o);

    // R7: the coefficient cannot change while a fill is running.
    assert_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(coef_o));

endmodule

// File: rtl/tlm_table_ram.sv
// Module: tlm_table_ram
// One copy of the multiple table. It has one write port and one read port,
// and the read data is registered. Reset clears every entry to zero.
// Assumes: reads and writes never happen in the same clock (the top
//          blocks reads while the table is being filled).
module tlm_table_ram #(
    parameter int ADDR_W  = 5,
    parameter int ENTRY_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [ENTRY_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    // Storage array: cleared by reset, written by the fill sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Registered read: captures the addressed entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= mem_q[rd_addr_i];
        end
    end

endmodule

// File: rtl/tlm_recombine.sv
// Module: tlm_recombine
// Second pipeline stage. Chunk i's partial product is shifted left by
// i*CHUNK_W, all of them are added, and the sum is registered. The output
// keeps its value when no valid input arrives.
// Assumes: PROD_W holds the full product, so the sum never wraps.
module tlm_recombine #(
    parameter int NCHUNK  = 2,
    parameter int CHUNK_W = 5,
    parameter int ENTRY_W = 18,
    parameter int PROD_W  = 23
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid_i,
    input  logic [NCHUNK-1:0][ENTRY_W-1:0] parts_i,
    output logic                           valid_o,
    output logic [PROD_W-1:0]              product_o
);

    logic [PROD_W-1:0] sum_c;

    // Weighted sum of the chunk partial products.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            sum_c = sum_c + (PROD_W'(parts_i[i]) << (i * CHUNK_W));
        end
    end

    // Output register: loads on valid, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            product_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                product_o <= sum_c;
            end
        end
    end

endmodule

// File: rtl/tlm_lut_mult.sv
// Module: tlm_lut_mult (top)
// Unsigned constant-coefficient multiplier built from lookup tables.
// The sample is cut into NCHUNK chunks. Each chunk addresses its own copy
// of the multiple table (stage 1), and the partial products are shifted
// and added (stage 2). Latency is two clocks. Samples arriving while the
// tables are being filled are dropped.
// Assumes: SAMPLE_W is a multiple of CHUNK_W; the coefficient is not
//          reloaded while results are still expected.
module tlm_lut_mult #(
    parameter int SAMPLE_W = 10,
    parameter int CHUNK_W  = 5,
    parameter int COEF_W   = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         coef_load_i,
    input  logic [COEF_W-1:0]            coef_i,
    output logic                         busy_o,
    input  logic                         valid_i,
    input  logic [SAMPLE_W-1:0]          sample_i,
    output logic                         valid_o,
    output logic [COEF_W+SAMPLE_W-1:0]   product_o
);

    localparam int NCHUNK  = SAMPLE_W / CHUNK_W;
    localparam int ENTRY_W = COEF_W + CHUNK_W;
    localparam int PROD_W  = COEF_W + SAMPLE_W;

    logic                           wr_en;
    logic [CHUNK_W-1:0]             wr_addr;
    logic [ENTRY_W-1:0]             wr_data;
    logic [COEF_W-1:0]              coef_cur;
    logic                           accept;
    logic                           valid_s1;
    logic [NCHUNK-1:0][ENTRY_W-1:0] parts;

    tlm_table_gen #(
        .COEF_W  (COEF_W),
        .ADDR_W  (CHUNK_W),
        .ENTRY_W (ENTRY_W)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (coef_load_i),
        .coef_i    (coef_i),
        .busy_o    (busy_o),
        .coef_o    (coef_cur),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    // A sample enters the pipeline only when no fill is running.
    always_comb begin
        accept = valid_i && !busy_o;
    end

    // Stage 1 qualifier: marks a table read that is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s1 <= 1'b0;
        end else begin
            valid_s1 <= accept;
        end
    end

    // One table copy per chunk, all written with the same data.
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        tlm_table_ram #(
            .ADDR_W  (CHUNK_W),
            .ENTRY_W (ENTRY_W)
        ) u_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en),
            .wr_addr_i (wr_addr),
            .wr_data_i (wr_data),
            .rd_en_i   (accept),
            .rd_addr_i (sample_i[g*CHUNK_W +: CHUNK_W]),
            .rd_data_o (parts[g])
        );
    end

    tlm_recombine #(
        .NCHUNK  (NCHUNK),
        .CHUNK_W (CHUNK_W),
        .ENTRY_W (ENTRY_W),
        .PROD_W  (PROD_W)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_s1),
        .parts_i   (parts),
        .valid_o   (valid_o),
        .product_o (product_o)
    );

    // R5: an accepted sample gives a result two clocks later.
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !busy_o) |=> ##1 valid_o);

    // R6: a sample presented during a fill produces no result.
    assert_drop_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && busy_o) |=> ##1 !valid_o);

    // R4: the result equals sample times coefficient as seen two clocks earlier.
    assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (product_o ==
            PROD_W'(PROD_W'($past(sample_i, 2)) * PROD_W'($past(coef_cur, 2)))));

    // R8: the output holds while no result is delivered.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(product_o));

endmodule

// File: tb/tlm_lut_mult_tb.sv
module tlm_lut_mult_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 10;
    localparam int CW = 13;
    localparam int PW = 23;
    localparam int NS = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_load_i = 1'b0;
    logic [CW-1:0] coef_i = '0;
    logic          busy_o;
    logic          valid_i = 1'b0;
    logic [SW-1:0] sample_i = '0;
    logic          valid_o;
    logic [PW-1:0] product_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    tlm_lut_mult u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .coef_load_i (coef_load_i),
        .coef_i      (coef_i),
        .busy_o      (busy_o),
        .valid_i     (valid_i),
        .sample_i    (sample_i),
        .valid_o     (valid_o),
        .product_o   (product_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a coefficient. R3: busy counts 32. With stress, samples and a
    // second load are driven during the fill (R6, R7).
    task automatic load_coef(input int c, input bit stress, input int other);
        int cnt;
        @(negedge clk);
        coef_load_i = 1'b1;
        coef_i = CW'(c);
        @(negedge clk);
        coef_load_i = 1'b0;
        cnt = 0;
        while (busy_o && cnt < 100) begin
            cnt++;
            if (stress) begin
                valid_i = 1'b1;
                sample_i = SW'(cnt * 37 + 5);
                coef_load_i = 1'b1;
                coef_i = CW'(other);
                check(valid_o == 1'b0, "R6", valid_o, 0);
            end
            @(negedge clk);
        end
        valid_i = 1'b0;
        coef_load_i = 1'b0;
        check(cnt == 32, "R3", cnt, 32);
        if (stress) begin
            for (int k = 0; k < 2; k++) begin
                check(valid_o == 1'b0, "R6", valid_o, 0);
                @(negedge clk);
            end
        end
    endtask

    // Stream all samples back to back and compare two edges later (R4, R5, R9).
    task automatic sweep(input int c);
        longint last;
        for (int k = 0; k < NS + 2; k++) begin
            if (k >= 2) begin
                check(valid_o == 1'b1, "R5", valid_o, 1);
                check(product_o == PW'((k - 2) * c), "R4/R9", product_o, (k - 2) * c);
            end
            if (k < NS) begin
                valid_i = 1'b1;
                sample_i = SW'(k);
            end else begin
                valid_i = 1'b0;
            end
            @(negedge clk);
        end
        check(valid_o == 1'b0, "R5", valid_o, 0);
        last = longint'(NS - 1) * c;
        repeat (3) @(negedge clk);
        check(product_o == PW'(last), "R8", product_o, last);
        check(valid_o == 1'b0, "R8", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(product_o == 0, "R1", product_o, 0);
        check(valid_o == 0, "R1", valid_o, 0);
        check(busy_o == 0, "R1", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 0 && busy_o == 0, "R1", valid_o, 0);

        // R2: tables are zero before any load.
        valid_i = 1'b1;
        sample_i = 10'd1023;
        @(negedge clk);
        valid_i = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b1, "R2", valid_o, 1);
        check(product_o == 0, "R2", product_o, 0);

        load_coef(8191, 0, 0);
        sweep(8191);
        load_coef(1, 0, 0);
        sweep(1);
        load_coef(5461, 1, 77);
        sweep(5461);
        load_coef(4660, 0, 0);
        sweep(4660);
        load_coef(0, 1, 8191);
        sweep(0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1;
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule